// File: doc/BRIEF.md
# March C- Memory Self-Test Controller

This block is an on-chip test engine placed beside one single-port synchronous SRAM with a one-cycle read latency. A pulse on `start` takes the memory port away from the functional logic. The engine then walks the six March C- elements over every address. Each read is compared with the background word it should return. The first mismatch is logged. When the last compare is done, the port goes back to functional use.

The six elements, indexed 0 to 5 in the order they run, are up(w0), up(r0,w1), up(r1,w0), down(r0,w1), down(r1,w0) and up(r0). The background words are all-zeros and all-ones, at the memory data width. The engine issues one memory operation per cycle, with no stalls, so a run over N words takes 10N operations. One more cycle follows to compare the final read. Address width and data width are parameters.

Top module: `march_bist`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low, and the memory port is in functional mode.
- R2: While `busy` is low, `memAddr`, `memWdata` and `memWe` equal `funcAddr`, `funcWdata` and `funcWe`, in the same cycle.
- R3: A `start` sampled while idle raises `busy` on the next cycle. `busy` then stays high for exactly 10N+1 cycles, where N = 2^ADDR_W. A `start` during a run has no effect on the run's operations or length.
- R4: Operation k of a run is issued in the k-th busy cycle, numbered from 0. The operations follow March C- exactly. Element 0 writes zeros. Elements 1 and 3 read and then write all-ones. Elements 2 and 4 read and then write zeros. Element 5 only reads. Every write drives `memWdata` to all-zeros or all-ones.
- R5: Elements 0, 1, 2 and 5 visit addresses from 0 up to N-1. Elements 3 and 4 visit them from N-1 down to 0. In the two-operation elements, the read of an address comes in the cycle before the write to that same address, and no cycle has both a read and a write. The busy cycle after the last read has no write.
- R6: On a memory with no faults, `fail` is low when `done` rises.
- R7: A stuck-at-1 bit is reported in element 1. `failElem` gives the element index, 0 to 5 in the order the elements run. `failAddr` is the faulty address. `failData` is the word read back, which has only the stuck bits set.
- R8: A stuck-at-0 bit, with no stuck-at-1 bit present, is reported in element 2. `failData` is all-ones except for the stuck bits.
- R9: Only the first mismatch is logged. When several addresses fail in the same element, the lowest address is the one reported, and the log does not change until the next start.
- R10: `done` is a one-cycle pulse, in the first cycle in which `busy` is low after a run. `fail` and the log hold until the next accepted `start`, and they are clear in the first busy cycle of the new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run when idle |
| busy | output | 1 | Test in progress; the engine owns the memory port |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky flag: a mismatch was seen |
| failElem | output | 3 | Element index (0 to 5) of the first mismatch |
| failAddr | output | ADDR_W | Address of the first mismatch |
| failData | output | DATA_W | Word read back at the first mismatch |
| funcAddr | input | ADDR_W | Functional-side address |
| funcWdata | input | DATA_W | Functional-side write data |
| funcWe | input | 1 | Functional-side write enable |
| memAddr | output | ADDR_W | Address to the SRAM |
| memWdata | output | DATA_W | Write data to the SRAM |
| memWe | output | 1 | Write enable to the SRAM |
| memRdata | input | DATA_W | Read data from the SRAM, valid one cycle after the read |

## Verification
A fault-free memory shows that the operation trace, the run length and the pass result all match the March C- schedule. A stuck-at-1 bit at address 0 and a stuck-at-0 bit at the top address, on the top data bit, check that each fault type is caught in its own element. They also check the address and data reported at both ends of the range. Runs with two stuck-at-1 words, and runs with random single faults of random type, position and bit, tell first-failure capture apart from a log that keeps being overwritten. Random functional-port traffic while the engine is idle, together with a stray `start` in the middle of a run, tests the port multiplexer and shows that a restart is ignored.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ELEM_W    = 3;
  localparam int LAST_ELEM = 5;

  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    logic              wrOne;
    logic              expOne;
    logic              clear;
    logic [ELEM_W-1:0] elem;
  } strobe_t;
endpackage

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] tAddr,
  output strobe_t           strb
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t            state;
  logic [ELEM_W-1:0] elem;
  logic              phase;
  logic              twoOp, down, nextDown, lastAddr, opDone, inRun;

  always_comb begin
    inRun    = (state == S_RUN);
    twoOp    = (elem >= 3'd1) && (elem <= 3'd4);
    down     = (elem == 3'd3) || (elem == 3'd4);
    nextDown = (elem == 3'd2) || (elem == 3'd3);
    lastAddr = down ? (tAddr == '0) : (tAddr == '1);
    opDone   = !twoOp || phase;
    busy     = (state != S_IDLE);

    strb.rdEn   = inRun && (elem != 3'd0) && (!twoOp || !phase);
    strb.wrEn   = inRun && ((elem == 3'd0) || (twoOp && phase));
    strb.wrOne  = (elem == 3'd1) || (elem == 3'd3);
    strb.expOne = (elem == 3'd2) || (elem == 3'd4);
    strb.clear  = (state == S_IDLE) && start;
    strb.elem   = elem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      elem  <= '0;
      phase <= 1'b0;
      tAddr <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == S_DRAIN);
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_RUN;
            elem  <= '0;
            phase <= 1'b0;
            tAddr <= '0;
          end
        end
        S_RUN: begin
          if (!opDone) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (lastAddr) begin
              if (elem == ELEM_W'(LAST_ELEM)) begin
                state <= S_DRAIN;
              end else begin
                elem  <= elem + 3'd1;
                tAddr <= nextDown ? '1 : '0;
              end
            end else begin
              tAddr <= down ? tAddr - 1'b1 : tAddr + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5: every element opens at the end of the range its direction starts from
  assert_elem_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && !$stable(elem)) |->
      (tAddr == (down ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}})));

  // R10: the end of busy coincides with done
  assert_done_on_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R10: done lasts a single cycle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/march_dp.sv
module march_dp
  import march_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] tAddr,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWdata,
  input  logic              funcWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              fail,
  output logic [ELEM_W-1:0] failElem,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData
);
  logic              pValid, pExp;
  logic [ADDR_W-1:0] pAddr;
  logic [ELEM_W-1:0] pElem;
  logic [DATA_W-1:0] expWord;
  logic              mismatch;

  always_comb begin
    memAddr  = busy ? tAddr : funcAddr;
    memWdata = busy ? {DATA_W{strb.wrOne}} : funcWdata;
    memWe    = busy ? strb.wrEn : funcWe;
    expWord  = {DATA_W{pExp}};
    mismatch = pValid && (memRdata != expWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pValid <= 1'b0;
      pExp   <= 1'b0;
      pAddr  <= '0;
      pElem  <= '0;
    end else begin
      pValid <= strb.rdEn;
      pExp   <= strb.expOne;
      pAddr  <= tAddr;
      pElem  <= strb.elem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fail     <= 1'b0;
      failElem <= '0;
      failAddr <= '0;
      failData <= '0;
    end else if (strb.clear) begin
      fail     <= 1'b0;
      failElem <= '0;
      failAddr <= '0;
      failData <= '0;
    end else if (mismatch && !fail) begin
      fail     <= 1'b1;
      failElem <= pElem;
      failAddr <= pAddr;
      failData <= memRdata;
    end
  end

  // R5: the control never asks for a read and a write in one cycle
  always_comb begin
    assert_one_op_R5: assert (!(strb.rdEn && strb.wrEn));
  end

  // R10: fail is sticky until a new run is accepted
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clear) |=> fail);

  // R9: once logged, the first failure is frozen
  assert_log_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !strb.clear) |=>
      ($stable(failAddr) && $stable(failElem) && $stable(failData)));
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [2:0]        failElem,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failData,
  input  logic [ADDR_W-1:0] funcAddr,
  input  logic [DATA_W-1:0] funcWdata,
  input  logic              funcWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata
);
  strobe_t           strb;
  logic [ADDR_W-1:0] tAddr;

  march_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .tAddr(tAddr), .strb(strb)
  );

  march_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .strb(strb), .tAddr(tAddr),
    .funcAddr(funcAddr), .funcWdata(funcWdata), .funcWe(funcWe),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .fail(fail), .failElem(failElem), .failAddr(failAddr), .failData(failData)
  );
endmodule

// File: tb/test_march_bist.sv
`timescale 1ns/1ps
module test_march_bist;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail;
  logic [2:0]    failElem;
  logic [AW-1:0] failAddr, funcAddr = '0, memAddr;
  logic [DW-1:0] failData, funcWdata = '0, memWdata, memRdata;
  logic          funcWe = 1'b0, memWe;

  logic [DW-1:0] mem [N];
  logic [DW-1:0] sa0 [N];
  logic [DW-1:0] sa1 [N];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW)) i_march_bist (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .fail(fail), .failElem(failElem), .failAddr(failAddr), .failData(failData),
    .funcAddr(funcAddr), .funcWdata(funcWdata), .funcWe(funcWe),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata)
  );

  // behavioural SRAM with stuck-at bits and one-cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= (memWdata & ~sa0[memAddr]) | sa1[memAddr];
    memRdata <= (mem[memAddr] & ~sa0[memAddr]) | sa1[memAddr];
  end

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected operation k of a March C- run
  function automatic void expOp(input int k, output bit we, output int a,
                                output bit one);
    if (k < N) begin
      we = 1'b1; a = k; one = 1'b0;
    end else if (k < 9 * N) begin
      int j, e, idx;
      j = k - N; e = 1 + j / (2 * N); idx = (j % (2 * N)) / 2;
      we = (j % 2) == 1;
      a = (e >= 3) ? N - 1 - idx : idx;
      one = (e == 1) || (e == 3);
    end else begin
      we = 1'b0; a = k - 9 * N; one = 1'b0;
    end
  endfunction

  // expected first failure for stuck-at faults only
  function automatic void expFail(output bit f, output int e, output int a,
                                  output logic [DW-1:0] d);
    f = 1'b0; e = 0; a = 0; d = '0;
    for (int i = 0; i < N; i++)
      if (!f && sa1[i] != '0) begin f = 1'b1; e = 1; a = i; d = sa1[i]; end
    for (int i = 0; i < N; i++)
      if (!f && (sa0[i] & ~sa1[i]) != '0) begin
        f = 1'b1; e = 2; a = i; d = ~sa0[i] | sa1[i];
      end
  endfunction

  task automatic clearFaults();
    for (int i = 0; i < N; i++) begin sa0[i] = '0; sa1[i] = '0; end
  endtask

  task automatic idleTraffic(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      funcAddr  = AW'($urandom);
      funcWdata = DW'($urandom);
      funcWe    = 1'($urandom);
      #1;
      check("R2", "memAddr", memAddr, funcAddr);
      check("R2", "memWdata", memWdata, funcWdata);
      check("R2", "memWe", memWe, funcWe);
      @(negedge clk);
    end
    funcWe = 1'b0;
  endtask

  task automatic runTest(input string name, input int strayAt);
    int cyc;
    bit we, one, ef;
    int a, ee, ea;
    logic [DW-1:0] ed;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    check("R10", {name, " fail cleared at start"}, fail, 0);
    while (busy && cyc <= 10 * N + 4) begin
      funcAddr  = AW'($urandom);
      funcWdata = DW'($urandom);
      funcWe    = 1'($urandom);
      start     = (cyc == strayAt);
      #1;
      if (cyc < 10 * N) begin
        expOp(cyc, we, a, one);
        check(cyc >= 3 * N ? "R5" : "R4", {name, " op we"}, memWe, we);
        check("R4", {name, " op addr"}, memAddr, a);
        if (we) check("R4", {name, " op data"}, memWdata, one ? {DW{1'b1}} : {DW{1'b0}});
      end else begin
        check("R5", {name, " drain no write"}, memWe, 0);
      end
      cyc++;
      @(negedge clk);
      start = 1'b0;
    end
    funcWe = 1'b0;
    check("R3", {name, " busy length"}, cyc, 10 * N + 1);
    check("R10", {name, " done pulse"}, done, 1);
    expFail(ef, ee, ea, ed);
    if (!ef) check("R6", {name, " pass"}, fail, 0);
    else begin
      check(ee == 1 ? "R7" : "R8", {name, " fail flag"}, fail, 1);
      check(ee == 1 ? "R7" : "R8", {name, " fail elem"}, failElem, ee);
      check("R9", {name, " fail addr"}, failAddr, ea);
      check(ee == 1 ? "R7" : "R8", {name, " fail data"}, failData, ed);
    end
    @(negedge clk);
    check("R10", {name, " done low"}, done, 0);
    check("R10", {name, " fail held"}, fail, ef);
  endtask

  initial begin
    void'($urandom(32'd1234));
    clearFaults();
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "fail", fail, 0);
    rstN = 1'b1;
    @(negedge clk);
    idleTraffic(12);

    runTest("clean", 37);

    sa1[0] = 8'h01;
    runTest("sa1 low", -1);
    clearFaults();

    sa0[N-1] = 8'h80;
    runTest("sa0 top", 5 * N);
    clearFaults();

    sa1[3] = 8'h10; sa1[11] = 8'h02;
    runTest("two sa1", -1);
    clearFaults();

    sa0[2] = 8'h04; sa0[9] = 8'h40;
    runTest("two sa0", -1);
    clearFaults();

    for (int r = 0; r < 4; r++) begin
      int fa = $urandom_range(N - 1);
      int fb = $urandom_range(DW - 1);
      if ($urandom_range(1) == 1) sa1[fa] = DW'(1) << fb;
      else sa0[fa] = DW'(1) << fb;
      idleTraffic(3);
      runTest("random", $urandom_range(10 * N));
      clearFaults();
    end

    runTest("clean again", -1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule